// File: doc/BRIEF.md
# Serialized Digital-Input SPI Slave

This block captures eight digital input levels and returns them to a controller over a four-wire serial link that uses clock polarity 0 and clock phase 0. When chip select falls, the block takes a snapshot of the inputs and two alarm levels and puts that frame into a shift register. The most significant bit goes onto the data output at once. On each serial clock cycle the block samples the incoming data bit on the rising edge and shifts the register on the falling edge.

The long frame is 16 bits. It holds the input states, two active-low alarm flags, four parity check bits formed by XNOR, a low stop bit and a high stop bit. The short frame holds the eight input bits and nothing else. A polarity pin inverts the output. When the power-good input is low, the output is forced to its "zero" level for the whole transfer, so a controller that reads the final stop bit as 0 knows that power was lost. Bits arriving on the serial input are shifted in behind the frame. Clock pulses beyond the frame length therefore pass those bits through, and several blocks can be chained.

All serial pins are resynchronised to the block clock. A three-state sequencer runs the transfer. ST_IDLE moves to ST_WAIT_RISE when the resynchronised chip select is seen low, and the frame is loaded on that move. ST_WAIT_RISE moves to ST_WAIT_FALL when the clock is seen high, and the serial input bit is captured. ST_WAIT_FALL moves back to ST_WAIT_RISE when the clock is seen low, and the register shifts. From any state, a high chip select returns the sequencer to ST_IDLE.

Top module: `dinser_top`

## Requirements
- R1: While chip select has been high, `spi_miso_oe` is 0 (the output is high-impedance), whatever the level of `power_good`.
- R2: A falling chip select loads the frame, and `spi_miso_oe` rises with the first frame bit already present on `spi_miso`, before any serial clock edge.
- R3: The register advances one bit per serial clock, on the falling edge only. A rising edge leaves `spi_miso` unchanged. Bits leave most significant first.
- R4: Long-frame layout (`short_frame`=0), bit 15 sent first: bits 15..8 = `in_state[7:0]`, bit 7 = NOT `uv_alarm`, bit 6 = NOT `ot_alarm`, bits 5..2 = check bits C1..C4, bit 1 = 0, bit 0 = 1.
- R5: Check bit Ck = XNOR(`in_state[k-1]`, `in_state[k+3]`) for k = 1..4. For example, inputs 8'b10011001 give C1..C4 = 1111.
- R6: With `short_frame`=1 the frame is `in_state[7:0]` only. After eight falling edges the serial input bits follow.
- R7: With `invert_out`=1, `spi_miso` carries the logical inverse of the serial data.
- R8: With `power_good`=0 and the output enabled, the serial data is 0 (`spi_miso` = `invert_out`) for every bit of the transfer.
- R9: After N falling edges (N = 16 or 8), `spi_miso` gives the serial input bits in the order they were received, so devices can be chained.
- R10: After reset the sequencer is idle and `spi_miso_oe` is 0.
- R11: Changes on `in_state` and on the alarm inputs after the frame is loaded have no effect on the data sent in that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data input |
| spi_miso | output | 1 | Serial data output (after power gate and polarity) |
| spi_miso_oe | output | 1 | Output enable; 0 means high-impedance |
| in_state | input | 8 | Digital input levels, bit 7 sent first |
| uv_alarm | input | 1 | Supply undervoltage alarm, active high |
| ot_alarm | input | 1 | Overtemperature alarm, active high |
| short_frame | input | 1 | 1 selects the 8-bit frame, 0 the 16-bit frame |
| invert_out | input | 1 | 1 inverts the serial output |
| power_good | input | 1 | 0 forces the serial data to 0 |

## Verification
A wrong sequencer state shows up at the ports within one serial clock half-period. A missed or repeated shift puts every later bit of the frame one place out, and a spurious shift on the rising edge shows up at the very next sample. A wrong load value or wrong parity shows up as soon as the affected bit reaches the output. Errors in the passthrough path appear only after the frame length has been clocked, so the daisy-chain frames clock eight bits beyond that length.

// File: rtl/dinser_pkg.sv
package dinser_pkg;

    localparam int INPUTS      = 8;
    localparam int FRAME_W     = 2 * INPUTS;
    localparam int SHORT_W     = INPUTS;
    localparam int CHECK_BITS  = INPUTS / 2;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_RISE,
        ST_WAIT_FALL
    } seq_state_t;

endpackage

// File: rtl/dinser_sync.sv
module dinser_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= RST_VAL;
        else        pipe[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= RST_VAL;
            else        pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/dinser_frame.sv
module dinser_frame
    import dinser_pkg::*;
(
    input  logic [INPUTS-1:0]  in_state,
    input  logic               uv_alarm,
    input  logic               ot_alarm,
    output logic [FRAME_W-1:0] frame
);

    localparam int CHK_TOP = 5;

    assign frame[FRAME_W-1 -: INPUTS] = in_state;
    assign frame[7] = ~uv_alarm;
    assign frame[6] = ~ot_alarm;

    // check bit k (1-based) sits at bit CHK_TOP-(k-1)
    for (genvar i = 0; i < CHECK_BITS; i++) begin : g_chk
        assign frame[CHK_TOP - i] = ~(in_state[i] ^ in_state[i + CHECK_BITS]);
    end

    assign frame[1] = 1'b0;
    assign frame[0] = 1'b1;

endmodule

// File: rtl/dinser_seq.sv
module dinser_seq
    import dinser_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_s,
    input  logic       sck_s,
    input  logic       mosi_s,
    output logic       load_en,
    output logic       shift_en,
    output logic       mosi_cap,
    output logic       active
);

    seq_state_t state, state_nxt;
    logic       cap_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        if (cs_s) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      state_nxt = ST_WAIT_RISE;
                ST_WAIT_RISE: if (sck_s)  state_nxt = ST_WAIT_FALL;
                ST_WAIT_FALL: if (!sck_s) state_nxt = ST_WAIT_RISE;
                default:      state_nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        load_en  = 1'b0;
        cap_en   = 1'b0;
        shift_en = 1'b0;
        active   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                load_en = !cs_s;
            end
            ST_WAIT_RISE: begin
                active = 1'b1;
                cap_en = !cs_s && sck_s;
            end
            ST_WAIT_FALL: begin
                active   = 1'b1;
                shift_en = !cs_s && !sck_s;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mosi_cap <= 1'b0;
        else if (cap_en) mosi_cap <= mosi_s;
    end

endmodule

// File: rtl/dinser_shreg.sv
module dinser_shreg
    import dinser_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic               shift_en,
    input  logic               short_sel,
    input  logic [FRAME_W-1:0] frame,
    input  logic               ser_in,
    output logic               ser_out
);

    localparam int SHORT_ENTRY = FRAME_W - SHORT_W;

    logic [FRAME_W-1:0] sr, sr_shift;
    logic               short_q;

    always_comb begin
        sr_shift = sr << 1;
        if (short_q) sr_shift[SHORT_ENTRY] = ser_in;
        else         sr_shift[0]           = ser_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr      <= '0;
            short_q <= 1'b0;
        end else if (load_en) begin
            sr      <= frame;
            short_q <= short_sel;
        end else if (shift_en) begin
            sr      <= sr_shift;
        end
    end

    assign ser_out = sr[FRAME_W-1];

endmodule

// File: rtl/dinser_top.sv
module dinser_top
    import dinser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic [INPUTS-1:0] in_state,
    input  logic              uv_alarm,
    input  logic              ot_alarm,
    input  logic              short_frame,
    input  logic              invert_out,
    input  logic              power_good
);

    logic [2:0]         pins_s;
    logic               sck_s, cs_s, mosi_s;
    logic               load_en, shift_en, mosi_cap, active;
    logic [FRAME_W-1:0] frame;
    logic               ser_out;
    logic               data_gated;

    dinser_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({spi_sck, spi_cs_n, spi_mosi}),
        .q    (pins_s)
    );

    assign sck_s  = pins_s[2];
    assign cs_s   = pins_s[1];
    assign mosi_s = pins_s[0];

    dinser_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_s    (cs_s),
        .sck_s   (sck_s),
        .mosi_s  (mosi_s),
        .load_en (load_en),
        .shift_en(shift_en),
        .mosi_cap(mosi_cap),
        .active  (active)
    );

    dinser_frame u_frame (
        .in_state(in_state),
        .uv_alarm(uv_alarm),
        .ot_alarm(ot_alarm),
        .frame   (frame)
    );

    dinser_shreg u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .shift_en (shift_en),
        .short_sel(short_frame),
        .frame    (frame),
        .ser_in   (mosi_cap),
        .ser_out  (ser_out)
    );

    assign data_gated  = power_good & ser_out;
    assign spi_miso    = active & (data_gated ^ invert_out);
    assign spi_miso_oe = active;

endmodule

// File: rtl/dinser_chk.sv
module dinser_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_cs_n,
    input logic spi_miso,
    input logic spi_miso_oe,
    input logic power_good,
    input logic invert_out,
    input logic load_en,
    input logic shift_en
);

    // R1
    cs_high_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> !spi_miso_oe);

    // R2
    enable_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_miso_oe) |-> $past(load_en));

    // R3
    hold_between_shifts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_miso_oe && $past(spi_miso_oe) && $stable(power_good) && $stable(invert_out)
         && !$past(shift_en) && !$past(load_en)) |-> $stable(spi_miso));

    // R8
    power_loss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!power_good && spi_miso_oe) |-> (spi_miso == invert_out));

endmodule

bind dinser_top dinser_chk u_chk (.*);

// File: tb/dinser_top_bench.sv
module dinser_top_bench;

    typedef struct {
        logic  exp_oe;
        logic  exp_d;
        string tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       spi_miso, spi_miso_oe;
    logic [7:0] in_state = '0;
    logic       uv_alarm = 1'b0, ot_alarm = 1'b0;
    logic       short_frame = 1'b0, invert_out = 1'b0, power_good = 1'b1;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    item_t sb_q[$];
    event  sample_ev;

    always #4 clk = ~clk;

    dinser_top u_dinser_top (.*);

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(input logic oe, input logic d, input string tag);
        item_t it;
        it.exp_oe = oe;
        it.exp_d  = d;
        it.tag    = tag;
        sb_q.push_back(it);
        -> sample_ev;
        #1;
    endtask

    initial begin : monitor
        forever begin
            @(sample_ev);
            if (sb_q.size() != 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_vec++;
                if (spi_miso_oe !== it.exp_oe || (it.exp_oe && spi_miso !== it.exp_d)) begin
                    n_bad++;
                    $display("FAIL %s: oe=%b d=%b expected oe=%b d=%b",
                             it.tag, spi_miso_oe, spi_miso, it.exp_oe, it.exp_d);
                end
            end
        end
    end

    function automatic logic [15:0] ref_frame(input logic [7:0] d, input logic uv, input logic ot);
        logic [15:0] f;
        f[15:8] = d;
        f[7] = ~uv;
        f[6] = ~ot;
        f[5] = ~(d[0] ^ d[4]);
        f[4] = ~(d[1] ^ d[5]);
        f[3] = ~(d[2] ^ d[6]);
        f[2] = ~(d[3] ^ d[7]);
        f[1] = 1'b0;
        f[0] = 1'b1;
        return f;
    endfunction

    task automatic run_frame(input logic [7:0] d, input logic uv, input logic ot,
                             input logic shrt, input logic inv, input logic pg,
                             input int nclk, input logic [31:0] pat,
                             input bit disturb, input string tag);
        logic [15:0] f;
        int          n;
        logic        bitv;
        f = ref_frame(d, uv, ot);
        n = shrt ? 8 : 16;
        in_state = d; uv_alarm = uv; ot_alarm = ot;
        short_frame = shrt; invert_out = inv; power_good = pg;
        idle(6);
        spi_cs_n = 1'b0;
        idle(8);
        bitv = pg & f[15];
        expect_now(1'b1, bitv ^ inv, {tag, " R2 first bit"});
        if (disturb) begin
            in_state = ~d; uv_alarm = ~uv; ot_alarm = ~ot;
        end
        for (int k = 1; k <= nclk; k++) begin
            spi_mosi = pat[32-k];
            idle(4);
            spi_sck = 1'b1;
            idle(8);
            expect_now(1'b1, bitv ^ inv, {tag, " R3 rise holds"});
            spi_sck = 1'b0;
            idle(8);
            if (k < n) bitv = pg & f[15-k];
            else       bitv = pg & pat[31-k+n];
            expect_now(1'b1, bitv ^ inv, {tag, $sformatf(" bit after %0d falls", k)});
        end
        spi_cs_n = 1'b1;
        idle(8);
        expect_now(1'b0, 1'b0, {tag, " R1 released"});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : driver
        idle(3);
        expect_now(1'b0, 1'b0, "R10 reset disabled");
        rst_n = 1'b1;
        idle(4);
        expect_now(1'b0, 1'b0, "R10 idle after reset");
        // R4 R5: 10011001 gives all-ones check bits
        run_frame(8'b10011001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16, 32'h0, 1'b0, "R5 parity 1111");
        run_frame(8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16, 32'hFFFF_0000, 1'b0, "R4 layout uv");
        run_frame(8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16, 32'h1234_5678, 1'b0, "R4 layout ot");
        // R9 daisy chain, 16-bit
        run_frame(8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 24, 32'hB6D9_2400, 1'b0, "R9 chain long");
        // R6 short frame with passthrough
        run_frame(8'h5A, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 14, 32'hC3A0_0000, 1'b0, "R6 short frame");
        // R7 inversion
        run_frame(8'h96, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16, 32'h0F00_0000, 1'b0, "R7 inverted");
        // R8 power loss
        run_frame(8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 18, 32'hFFFF_FFFF, 1'b0, "R8 power loss");
        run_frame(8'h81, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16, 32'hAAAA_AAAA, 1'b0, "R8 power loss inv");
        // R11 inputs disturbed after load
        run_frame(8'hF0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16, 32'h0, 1'b1, "R11 snapshot");
        // R1 with power lost and chip select high
        power_good = 1'b0;
        idle(6);
        expect_now(1'b0, 1'b0, "R1 idle with power lost");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule